// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table out of memory. A client hands it one address at a time, together with a flag that says whether the access is a write. The walker fetches the top-level entry, checks it and, unless that entry maps a 4 MB large page, fetches the second-level entry and checks that one too. The physical address is formed by substituting the frame bits from the final entry for the page-number bits of the virtual address. The offset bits are copied through unchanged, so no adder sits on the result path.

Software points the walker at the top-level table by loading a root register. A walk takes its root from a snapshot made when the request is accepted, so software may reload the root at any time without disturbing a walk in flight. The memory side is a single read port that has at most one read outstanding. Each result leaves on a response port that holds its value until the client takes it, and no new request is accepted before then.

Top module: `pgwalk_top`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and mem_req_valid is 0.
- R2: The first read of a walk goes to the root frame (root bits 31:12) followed by virtual address bits 31:22 and then two zero bits, so the address is the table base plus four times the top index.
- R3: When the top-level entry is present, grants the access and has bit 7 clear, a second read goes to entry bits 31:12 followed by virtual address bits 21:12 and then two zero bits.
- R4: A successful two-read walk reports rsp_fault 0, rsp_large 0 and a physical address made of second-level entry bits 31:12 above virtual address bits 11:0.
- R5: A present top-level entry with bit 7 set ends the walk after a single read, with rsp_large 1 and a physical address made of entry bits 31:22 above virtual address bits 21:0.
- R6: An entry whose bit 0 is clear ends the walk with rsp_fault 1 (not present), rsp_level 0 for the top level or 1 for the second level, and no further read. Presence is tested before any other bit.
- R7: A write (req_write 1) through a present entry whose bit 1 is clear ends the walk with rsp_fault 2 (protection) and the faulting level. Reads through such entries succeed.
- R8: Only one walk is in progress at a time. req_ready stays 0 from acceptance until the response is taken, and the response holds its fields stable while rsp_ready is 0.
- R9: A root register write made while a walk is running is not used by that walk, only by the next one.
- R10: A memory request keeps mem_req_valid high and its address stable until mem_req_ready is seen. No request is issued while a response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| root_wr | input | 1 | Loads the root register |
| root_wdata | input | 32 | New root value; bits 31:12 are the top table frame |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Client takes the result |
| rsp_paddr | output | 32 | Physical address, zero on a fault |
| rsp_fault | output | 2 | 0 none, 1 not present, 2 protection |
| rsp_level | output | 1 | Level that faulted: 0 top, 1 second |
| rsp_large | output | 1 | Result came from a 4 MB page |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Table entry |

## Verification
The bench targets the checks that sit between the two reads. A walker that tested the write bit before the present bit would report a protection fault on an absent entry. One that ignored bit 7 would issue a stray second read and return a 4 KB-aligned address for a large page. One that skipped the top-level write check would let a write through a read-only directory reach the second level. Wrong index slicing or base alignment shows up as a bad read address. The bench also stalls the memory port and the response port, and reloads the root in the middle of a walk, to catch a walker that drops a held request or reads the live root instead of its snapshot.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  localparam int VA_W       = 32;
  localparam int PTE_W      = 32;
  localparam int OFF_W      = 12;
  localparam int IDX_W      = 10;
  localparam int ENT_LOG    = 2;
  localparam int BIG_OFF_W  = OFF_W + IDX_W;
  localparam int FRAME_W    = VA_W - OFF_W;
  localparam int BIG_FRAME_W = VA_W - BIG_OFF_W;
  localparam int PRES_BIT   = 0;
  localparam int WR_BIT     = 1;
  localparam int BIG_BIT    = 7;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ABSENT = 2'd1,
    FLT_PROT   = 2'd2
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_RESP
  } walk_st_e;

  function automatic logic [IDX_W-1:0] top_index(input logic [VA_W-1:0] va);
    return va[VA_W-1 -: IDX_W];
  endfunction

  function automatic logic [IDX_W-1:0] low_index(input logic [VA_W-1:0] va);
    return va[OFF_W +: IDX_W];
  endfunction

  function automatic logic [VA_W-1:0] entry_addr(input logic [FRAME_W-1:0] frame,
                                                 input logic [IDX_W-1:0] idx);
    return {frame, idx, {ENT_LOG{1'b0}}};
  endfunction

  function automatic logic [VA_W-1:0] join_small(input logic [PTE_W-1:0] pte,
                                                 input logic [VA_W-1:0] va);
    return {pte[PTE_W-1 -: FRAME_W], va[OFF_W-1:0]};
  endfunction

  function automatic logic [VA_W-1:0] join_big(input logic [PTE_W-1:0] pte,
                                               input logic [VA_W-1:0] va);
    return {pte[PTE_W-1 -: BIG_FRAME_W], va[BIG_OFF_W-1:0]};
  endfunction

  function automatic fault_e judge(input logic [PTE_W-1:0] pte, input logic is_write);
    if (!pte[PRES_BIT])               return FLT_ABSENT;
    else if (is_write && !pte[WR_BIT]) return FLT_PROT;
    else                               return FLT_NONE;
  endfunction
endpackage

// File: rtl/pgwalk_root.sv
module pgwalk_root
  import pgwalk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [VA_W-1:0]    wr_data,
  input  logic               take,
  output logic [FRAME_W-1:0] snap_frame
);
  logic [FRAME_W-1:0] live_q;
  logic [FRAME_W-1:0] snap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      snap_q <= '0;
    end else begin
      if (wr_en) live_q <= wr_data[VA_W-1 -: FRAME_W];
      if (take)  snap_q <= live_q;
    end
  end

  assign snap_frame = snap_q;
endmodule

// File: rtl/pgwalk_eval.sv
module pgwalk_eval
  import pgwalk_pkg::*;
(
  input  logic [PTE_W-1:0]   pte,
  input  logic               lvl2,
  input  logic               is_write,
  input  logic [VA_W-1:0]    va,
  input  logic [FRAME_W-1:0] root_frame,
  input  logic [FRAME_W-1:0] tbl_frame,
  output logic [VA_W-1:0]    addr_l1,
  output logic [VA_W-1:0]    addr_l2,
  output fault_e             fault,
  output logic               big,
  output logic [VA_W-1:0]    paddr,
  output logic [FRAME_W-1:0] next_frame
);
  always_comb begin
    addr_l1    = entry_addr(root_frame, top_index(va));
    addr_l2    = entry_addr(tbl_frame, low_index(va));
    fault      = judge(pte, is_write);
    big        = !lvl2 && pte[BIG_BIT];
    paddr      = big ? join_big(pte, va) : join_small(pte, va);
    next_frame = pte[PTE_W-1 -: FRAME_W];
  end
endmodule

// File: rtl/pgwalk_fsm.sv
module pgwalk_fsm
  import pgwalk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic               rsp_ready,
  input  logic               mem_req_ready,
  input  logic               mem_rsp_valid,
  input  fault_e             ev_fault,
  input  logic               ev_big,
  input  logic [VA_W-1:0]    ev_paddr,
  input  logic [FRAME_W-1:0] ev_next_frame,
  output walk_st_e           state,
  output logic [VA_W-1:0]    va_q,
  output logic               wr_q,
  output logic [FRAME_W-1:0] tbl_q,
  output logic               accept,
  output logic               rsp_valid,
  output logic [VA_W-1:0]    paddr_q,
  output fault_e             fault_q,
  output logic               level_q,
  output logic               large_q
);
  walk_st_e st_q;

  assign accept    = (st_q == ST_IDLE) && req_valid;
  assign rsp_valid = (st_q == ST_RESP);
  assign state     = st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      tbl_q   <= '0;
      paddr_q <= '0;
      fault_q <= FLT_NONE;
      level_q <= 1'b0;
      large_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid) begin
          va_q  <= req_vaddr;
          wr_q  <= req_write;
          st_q  <= ST_L1_REQ;
        end
        ST_L1_REQ: if (mem_req_ready) st_q <= ST_L1_WAIT;
        ST_L1_WAIT: if (mem_rsp_valid) begin
          level_q <= 1'b0;
          if (ev_fault != FLT_NONE) begin
            fault_q <= ev_fault;
            paddr_q <= '0;
            large_q <= 1'b0;
            st_q    <= ST_RESP;
          end else if (ev_big) begin
            fault_q <= FLT_NONE;
            paddr_q <= ev_paddr;
            large_q <= 1'b1;
            st_q    <= ST_RESP;
          end else begin
            tbl_q   <= ev_next_frame;
            st_q    <= ST_L2_REQ;
          end
        end
        ST_L2_REQ: if (mem_req_ready) st_q <= ST_L2_WAIT;
        ST_L2_WAIT: if (mem_rsp_valid) begin
          level_q <= 1'b1;
          large_q <= 1'b0;
          fault_q <= ev_fault;
          paddr_q <= (ev_fault == FLT_NONE) ? ev_paddr : '0;
          st_q    <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        root_wr,
  input  logic [31:0] root_wdata,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  input  logic        req_write,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_paddr,
  output logic [1:0]  rsp_fault,
  output logic        rsp_level,
  output logic        rsp_large,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data
);
  walk_st_e           state;
  logic [VA_W-1:0]    walk_va;
  logic               walk_wr;
  logic [FRAME_W-1:0] tbl_frame;
  logic [FRAME_W-1:0] root_frame;
  logic               ev_accept;
  fault_e             ev_fault;
  logic               ev_big;
  logic [VA_W-1:0]    ev_paddr;
  logic [FRAME_W-1:0] ev_next_frame;
  logic [VA_W-1:0]    addr_l1;
  logic [VA_W-1:0]    addr_l2;
  logic [VA_W-1:0]    paddr_q;
  fault_e             fault_q;
  logic               in_l2;
  logic               ev_done;

  pgwalk_root i_root (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (root_wr),
    .wr_data    (root_wdata),
    .take       (ev_accept),
    .snap_frame (root_frame)
  );

  assign in_l2 = (state == ST_L2_WAIT);

  pgwalk_eval i_eval (
    .pte        (mem_rsp_data),
    .lvl2       (in_l2),
    .is_write   (walk_wr),
    .va         (walk_va),
    .root_frame (root_frame),
    .tbl_frame  (tbl_frame),
    .addr_l1    (addr_l1),
    .addr_l2    (addr_l2),
    .fault      (ev_fault),
    .big        (ev_big),
    .paddr      (ev_paddr),
    .next_frame (ev_next_frame)
  );

  pgwalk_fsm i_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_vaddr     (req_vaddr),
    .rsp_ready     (rsp_ready),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .ev_fault      (ev_fault),
    .ev_big        (ev_big),
    .ev_paddr      (ev_paddr),
    .ev_next_frame (ev_next_frame),
    .state         (state),
    .va_q          (walk_va),
    .wr_q          (walk_wr),
    .tbl_q         (tbl_frame),
    .accept        (ev_accept),
    .rsp_valid     (rsp_valid),
    .paddr_q       (paddr_q),
    .fault_q       (fault_q),
    .level_q       (rsp_level),
    .large_q       (rsp_large)
  );

  assign req_ready     = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_L1_REQ) || (state == ST_L2_REQ);
  assign mem_req_addr  = (state == ST_L2_REQ) ? addr_l2 : addr_l1;
  assign rsp_paddr     = paddr_q;
  assign rsp_fault     = fault_q;
  assign ev_done       = rsp_valid && rsp_ready;
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_paddr,
  input logic [1:0]  rsp_fault,
  input logic        rsp_large,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr,
  input logic [31:0] walk_va,
  input logic        ev_accept,
  input logic        ev_done
);
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> !req_ready); // R8

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)); // R8

  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> req_ready && !rsp_valid); // R8

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R10

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !mem_req_valid && !req_ready); // R10

  AST_ENTRY_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[1:0] == 2'b00); // R2

  AST_SMALL_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault == 2'd0 && !rsp_large |-> rsp_paddr[11:0] == walk_va[11:0]); // R4

  AST_BIG_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_large |-> rsp_paddr[21:0] == walk_va[21:0] && rsp_fault == 2'd0); // R5
endmodule

bind pgwalk_top pgwalk_chk i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_paddr     (rsp_paddr),
  .rsp_fault     (rsp_fault),
  .rsp_large     (rsp_large),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .walk_va       (walk_va),
  .ev_accept     (ev_accept),
  .ev_done       (ev_done)
);

// File: tb/test_pgwalk_top.sv
`timescale 1ns/1ps
module test_pgwalk_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        root_wr = 1'b0;
  logic [31:0] root_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_fault;
  logic        rsp_level;
  logic        rsp_large;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  always #2.5 clk = ~clk;

  pgwalk_top i_pgwalk_top (.*);

  typedef struct packed {
    logic [31:0] va;
    logic        wr;
    logic [31:0] p1;
    logic [31:0] p2;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0040_1234, 1'b0, 32'h0020_0003, 32'h0ABC_D003},  // R4 plain read
    '{32'hFFC0_0FFF, 1'b1, 32'h0030_0003, 32'h1234_5003},  // R4 write allowed
    '{32'h8123_4567, 1'b0, 32'h0C00_0081, 32'h0000_0000},  // R5 large
    '{32'h0040_1234, 1'b0, 32'h0020_0002, 32'h0000_0000},  // R6 top absent
    '{32'h0040_1234, 1'b0, 32'h0020_0003, 32'h0ABC_D002},  // R6 second absent
    '{32'h0040_1234, 1'b1, 32'h0020_0001, 32'h0000_0000},  // R7 top read-only
    '{32'h1234_5678, 1'b1, 32'h0020_0003, 32'h0ABC_D001},  // R7 second read-only
    '{32'h1234_5678, 1'b0, 32'h0020_0001, 32'h0ABC_D001},  // R7 read through read-only
    '{32'h8123_4567, 1'b1, 32'h0C00_0081, 32'h0000_0000},  // R7 large read-only write
    '{32'h8123_4567, 1'b0, 32'h0C00_0080, 32'h0000_0000}   // R6 large bit but absent
  };

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  logic [31:0] cur_root = 32'h0010_0000;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_walk(input logic [31:0] va, input logic wr, input logic [31:0] p1,
                          input logic [31:0] p2, input bit stall, input bit poke,
                          input logic [31:0] poke_val);
    logic [31:0] ea1, ea2, epa;
    logic [1:0]  eflt;
    logic        elvl, ebig;
    int          ereads, nreads;
    logic [31:0] held;
    // reference: arithmetic form of the walk
    ea1 = (cur_root - (cur_root % 4096)) + (va / 32'h0040_0000) * 4;
    ea2 = (p1 - (p1 % 4096)) + ((va / 4096) % 1024) * 4;
    epa = 0; eflt = 0; elvl = 0; ebig = 0; ereads = 1;
    if (p1 % 2 == 0) eflt = 1;
    else if (wr && ((p1 / 2) % 2 == 0)) eflt = 2;
    else if ((p1 / 128) % 2 == 1) begin
      ebig = 1;
      epa = (p1 - (p1 % 32'h0040_0000)) + (va % 32'h0040_0000);
    end else begin
      ereads = 2; elvl = 1;
      if (p2 % 2 == 0) eflt = 1;
      else if (wr && ((p2 / 2) % 2 == 0)) eflt = 2;
      else epa = (p2 - (p2 % 4096)) + (va % 4096);
    end

    @(negedge clk);
    chk("R8 req_ready idle before request", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_vaddr = va; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin root_wr = 1'b1; root_wdata = poke_val; end
    nreads = 0;
    for (int cyc = 0; cyc < 40 && !rsp_valid; cyc++) begin
      if (req_ready) chk("R8 req_ready low during walk", {31'd0, req_ready}, 32'd0);
      if (mem_req_valid) begin
        chk((nreads == 0) ? "R2 top entry address" : "R3 second entry address",
            mem_req_addr, (nreads == 0) ? ea1 : ea2);
        if (stall) begin
          held = mem_req_addr;
          @(negedge clk);
          root_wr = 1'b0;
          chk("R10 request held while not ready", {mem_req_valid, mem_req_addr[30:0]},
              {1'b1, held[30:0]});
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        root_wr = 1'b0;
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b1;
        mem_rsp_data = (nreads == 0) ? p1 : p2;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        nreads++;
      end else begin
        @(negedge clk);
        root_wr = 1'b0;
      end
    end
    if (poke) cur_root = poke_val;

    chk("R8 response present", {31'd0, rsp_valid}, 32'd1);
    chk(ebig ? "R5 read count" : (eflt != 0 ? "R6/R7 read count" : "R3 read count"),
        nreads, ereads);
    chk(eflt == 2 ? "R7 fault code" : "R6 fault code", {30'd0, rsp_fault}, {30'd0, eflt});
    chk("R6 fault level", {31'd0, rsp_level}, {31'd0, elvl});
    chk("R5 large flag", {31'd0, rsp_large}, {31'd0, ebig});
    if (eflt == 0) chk(ebig ? "R5 large paddr" : "R4 paddr", rsp_paddr, epa);
    chk("R10 no read while response pending", {31'd0, mem_req_valid}, 32'd0);
    held = rsp_paddr;
    @(negedge clk);
    chk("R8 response held", {rsp_valid, rsp_paddr[30:0]}, {1'b1, held[30:0]});
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R8 idle after response taken", {30'd0, req_ready, rsp_valid}, 32'd2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset req_ready", {31'd0, req_ready}, 32'd1);
    chk("R1 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R1 reset mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {30'd0, req_ready, mem_req_valid}, 32'd2);
    root_wr = 1'b1; root_wdata = cur_root;
    @(negedge clk);
    root_wr = 1'b0;

    for (int i = 0; i < NVEC; i++)
      run_walk(VECS[i].va, VECS[i].wr, VECS[i].p1, VECS[i].p2, (i % 2) == 1, 1'b0, '0);

    // R9: root reloaded mid-walk; this walk keeps the old root
    run_walk(32'h0080_3456, 1'b0, 32'h0020_0003, 32'h0ABC_D003, 1'b1, 1'b1, 32'h0055_5ABC);
    // R9: next walk uses the new root
    run_walk(32'h0080_3456, 1'b0, 32'h0020_0003, 32'h0ABC_D003, 1'b0, 1'b0, '0);
    // R2: top index at the last slot with a new root
    run_walk(32'hFFFF_FFFF, 1'b1, 32'hFFC0_0083, 32'h0000_0000, 1'b0, 1'b0, '0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule